// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds the single atomic reservation of a 32-bit processor with one hardware thread. Every cycle it may receive one memory operation: the 6-bit major opcode taken from instruction bits [31:26], the effective address that address generation has already computed, and the store data. A load-linked word records its address as the reservation and arms it. A store-conditional word succeeds only while the reservation is armed and its address matches the recorded one. The monitor gates the memory write of the store-conditional and reports the outcome through the processor's condition flag.

Ordinary byte, halfword and word stores pass through the monitor to memory with byte enables that it derives. A plain store that lands anywhere in the reserved word cancels the reservation. A store-conditional disarms the reservation every time, whether it succeeds or fails. The monitor drives combinational outputs in the cycle an operation is presented. The reservation state changes at the following rising clock edge.

Top module: `llsc_monitor`

## Requirements
- R1: After synchronous reset no reservation exists, and the recorded address is 0. A store-conditional issued first, even to address 0, fails.
- R2: Opcodes are read only while `op_valid` is 1. 0x1B is load-linked, 0x33 is store-conditional, 0x35 is a word store, 0x36 is a byte store and 0x37 is a halfword store. Any other opcode, or `op_valid` low, produces no memory write, no flag strobe and no change to the reservation.
- R3: A load-linked arms the reservation and records its full 32-bit address. A later load-linked replaces the recorded address.
- R4: A store-conditional whose address exactly equals the recorded address while the reservation is armed raises `flag_we` with `flag_val`=1. In the same cycle it drives `mem_we`=1, `mem_be`=4'b1111, `mem_addr` equal to the address and `mem_wdata` equal to the store data.
- R5: A store-conditional with no armed reservation, or with any address bit different from the recorded one (the low two bits included), raises `flag_we` with `flag_val`=0 and drives `mem_we`=0.
- R6: Every store-conditional disarms the reservation. A second store-conditional to the same address right after it fails.
- R7: An ordinary store whose address, with bits [1:0] cleared, equals the recorded address disarms the reservation. The store itself is still written to memory.
- R8: An ordinary store to any other word leaves both the armed state and the recorded address unchanged.
- R9: Ordinary-store byte enables are little-endian, with bit i standing for byte offset i. A byte store enables only bit addr[1:0]. A halfword store enables bits {1,0} when addr[1]=0 and bits {3,2} when addr[1]=1. A word store enables all four. `mem_addr` and `mem_wdata` pass the operation's address and data unchanged.
- R10: `flag_we` is high only in the cycle of a store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | A memory operation is presented this cycle |
| op_code | input | 6 | Major opcode of the operation |
| op_addr | input | 32 | Computed effective address |
| op_wdata | input | 32 | Store data (low 32 bits of the source register) |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Byte enables of the write |
| mem_addr | output | 32 | Write address |
| mem_wdata | output | 32 | Write data |
| flag_we | output | 1 | Condition-flag update strobe |
| flag_val | output | 1 | New condition-flag value |

## Verification
A store-conditional does two things in one cycle: it reads the armed state to decide success, and it disarms the reservation at the same edge. The bench provokes this with back-to-back store-conditionals to one address, where the first must succeed and the second must fail. It also issues store-conditionals directly after load-linked operations, to confirm that the freshly armed state is seen in the very next cycle. A behavioural reservation model in the bench judges every cycle. That includes long random runs in which addresses are drawn from a small pool, so that plain stores, reservations and conditionals collide often within the same word and at different byte offsets.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;
  parameter int unsigned AW   = 32;
  parameter int unsigned DW   = 32;
  parameter int unsigned OPW  = 6;
  localparam int unsigned BEW = DW / 8;
  localparam int unsigned LOW = $clog2(BEW);

  localparam logic [OPW-1:0] OPC_LL  = 6'h1B;
  localparam logic [OPW-1:0] OPC_SC  = 6'h33;
  localparam logic [OPW-1:0] OPC_SW  = 6'h35;
  localparam logic [OPW-1:0] OPC_SB  = 6'h36;
  localparam logic [OPW-1:0] OPC_SH  = 6'h37;

  typedef enum logic [1:0] {K_NONE, K_LL, K_SC, K_ST} op_kind_e;
  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W} st_size_e;

  // Address of the word that contains a byte address.
  function automatic logic [AW-1:0] word_base(input logic [AW-1:0] a);
    return {a[AW-1:LOW], {LOW{1'b0}}};
  endfunction

  // Little-endian byte enables for an ordinary store.
  function automatic logic [BEW-1:0] lane_mask(input st_size_e sz,
                                               input logic [LOW-1:0] lo);
    logic [BEW-1:0] m;
    case (sz)
      SZ_B:    m = {{(BEW-1){1'b0}}, 1'b1} << lo;
      SZ_H:    m = {{(BEW-2){1'b0}}, 2'b11} << {lo[LOW-1:1], 1'b0};
      default: m = {BEW{1'b1}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/llsc_decode.sv
`timescale 1ns/1ps
module llsc_decode
  import llsc_pkg::*;
(
  input  logic           valid,
  input  logic [OPW-1:0] opcode,
  output op_kind_e       kind,
  output st_size_e       size
);
  always_comb begin
    kind = K_NONE;
    size = SZ_W;
    if (valid) begin
      case (opcode)
        OPC_LL: kind = K_LL;
        OPC_SC: kind = K_SC;
        OPC_SW: begin kind = K_ST; size = SZ_W; end
        OPC_SB: begin kind = K_ST; size = SZ_B; end
        OPC_SH: begin kind = K_ST; size = SZ_H; end
        default: kind = K_NONE;
      endcase
    end
  end

  // R2: nothing is recognised without a valid operation
  always_comb begin
    if (!valid) a_r2_idle_no_kind: assert (kind == K_NONE);
  end
endmodule

// File: rtl/llsc_resv.sv
`timescale 1ns/1ps
module llsc_resv
  import llsc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  op_kind_e      kind,
  input  logic [AW-1:0] addr,
  output logic          sc_pass,
  output logic          ev_ll,
  output logic          ev_sc,
  output logic          ev_st_hit,
  output logic          ev_st_miss
);
  logic          rsv_valid;
  logic [AW-1:0] rsv_addr;
  logic          same_word;

  assign same_word  = (word_base(addr) == rsv_addr);
  assign ev_ll      = (kind == K_LL);
  assign ev_sc      = (kind == K_SC);
  assign ev_st_hit  = (kind == K_ST) && same_word;
  assign ev_st_miss = (kind == K_ST) && !same_word;
  assign sc_pass    = ev_sc && rsv_valid && (addr == rsv_addr);

  // Arming takes priority over every clearing source.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsv_valid <= 1'b0;
      rsv_addr  <= '0;
    end else if (ev_ll) begin
      rsv_valid <= 1'b1;
      rsv_addr  <= addr;
    end else if (ev_sc || ev_st_hit) begin
      rsv_valid <= 1'b0;
    end
  end

  a_r3_ll_arms: assert property (@(posedge clk) disable iff (rst)
    ev_ll |=> (rsv_valid && rsv_addr == $past(addr)));
  a_r6_sc_disarms: assert property (@(posedge clk) disable iff (rst)
    ev_sc |=> !rsv_valid);
  a_r7_store_hit_disarms: assert property (@(posedge clk) disable iff (rst)
    ev_st_hit |=> !rsv_valid);
  a_r8_store_miss_keeps: assert property (@(posedge clk) disable iff (rst)
    ev_st_miss |=> (rsv_valid == $past(rsv_valid) && $stable(rsv_addr)));
  a_r2_idle_keeps: assert property (@(posedge clk) disable iff (rst)
    (kind == K_NONE) |=> (rsv_valid == $past(rsv_valid) && $stable(rsv_addr)));
endmodule

// File: rtl/llsc_wgate.sv
`timescale 1ns/1ps
module llsc_wgate
  import llsc_pkg::*;
(
  input  op_kind_e       kind,
  input  st_size_e       size,
  input  logic           sc_pass,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic           mem_we,
  output logic [BEW-1:0] mem_be,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           flag_we,
  output logic           flag_val
);
  always_comb begin
    mem_we    = 1'b0;
    mem_be    = '0;
    flag_we   = 1'b0;
    flag_val  = 1'b0;
    mem_addr  = addr;
    mem_wdata = wdata;
    case (kind)
      K_SC: begin
        flag_we  = 1'b1;
        flag_val = sc_pass;
        mem_we   = sc_pass;
        mem_be   = sc_pass ? {BEW{1'b1}} : '0;
      end
      K_ST: begin
        mem_we = 1'b1;
        mem_be = lane_mask(size, addr[LOW-1:0]);
      end
      default: ;
    endcase
  end

  always_comb begin
    // R4: a successful conditional writes a full word
    if (flag_we && flag_val) a_r4_pass_full_word: assert (mem_we && mem_be == {BEW{1'b1}});
    // R5: a failed conditional issues no write
    if (flag_we && !flag_val) a_r5_fail_no_write: assert (!mem_we);
    // R10: strobe only for conditional stores
    if (flag_we) a_r10_strobe_only_sc: assert (kind == K_SC);
    // R9: a write always has at least one lane
    if (mem_we) a_r9_lanes_present: assert (mem_be != '0);
  end
endmodule

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
module llsc_monitor
  import llsc_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [AW-1:0]  op_addr,
  input  logic [DW-1:0]  op_wdata,
  output logic           mem_we,
  output logic [BEW-1:0] mem_be,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           flag_we,
  output logic           flag_val
);
  op_kind_e kind;
  st_size_e size;
  logic     sc_pass, ev_ll, ev_sc, ev_st_hit, ev_st_miss;

  llsc_decode u_dec (
    .valid (op_valid), .opcode (op_code), .kind (kind), .size (size)
  );

  llsc_resv u_resv (
    .clk (clk), .rst (rst), .kind (kind), .addr (op_addr),
    .sc_pass (sc_pass), .ev_ll (ev_ll), .ev_sc (ev_sc),
    .ev_st_hit (ev_st_hit), .ev_st_miss (ev_st_miss)
  );

  llsc_wgate u_gate (
    .kind (kind), .size (size), .sc_pass (sc_pass), .addr (op_addr),
    .wdata (op_wdata), .mem_we (mem_we), .mem_be (mem_be),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .flag_we (flag_we), .flag_val (flag_val)
  );

  // R6: two conditionals in a row cannot both succeed
  a_r6_no_double_pass: assert property (@(posedge clk) disable iff (rst)
    (flag_we && flag_val) |=> !(flag_we && flag_val));
  // R7: a plain store always reaches memory
  a_r7_store_proceeds: assert property (@(posedge clk) disable iff (rst)
    (ev_st_hit || ev_st_miss) |-> mem_we);
  // R3: a conditional right after a load-linked to the same address passes
  a_r3_ll_then_sc: assert property (@(posedge clk) disable iff (rst)
    (ev_ll ##1 (ev_sc && op_addr == $past(op_addr))) |-> flag_val);
endmodule

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [5:0]  op_code = 6'h00;
  logic [31:0] op_addr = 32'h0;
  logic [31:0] op_wdata = 32'h0;
  logic        mem_we, flag_we, flag_val;
  logic [3:0]  mem_be;
  logic [31:0] mem_addr, mem_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // behavioural reservation model
  bit          m_arm = 1'b0;
  logic [31:0] m_adr = 32'h0;

  always #2.5 clk = ~clk;

  llsc_monitor dut_i (
    .clk (clk), .rst (rst), .op_valid (op_valid), .op_code (op_code),
    .op_addr (op_addr), .op_wdata (op_wdata), .mem_we (mem_we),
    .mem_be (mem_be), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .flag_we (flag_we), .flag_val (flag_val)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one operation per cycle: drive after the falling edge, judge before the rising edge
  task automatic step(input bit v, input logic [5:0] opc,
                      input logic [31:0] a, input logic [31:0] d, input string tag);
    bit is_ll, is_sc, is_st, pass;
    int nbytes;
    logic [3:0] be;
    @(negedge clk);
    op_valid = v; op_code = opc; op_addr = a; op_wdata = d;
    #1;
    is_ll = v && opc == 6'h1B;
    is_sc = v && opc == 6'h33;
    is_st = v && (opc == 6'h35 || opc == 6'h36 || opc == 6'h37);
    pass  = is_sc && m_arm && a == m_adr;
    nbytes = (opc == 6'h36) ? 1 : (opc == 6'h37) ? 2 : 4;
    be = 4'b0000;
    for (int i = 0; i < 4; i++)
      if (is_sc ? pass : is_st && (i / nbytes) == ((a % 4) / nbytes)) be[i] = 1'b1;
    chk(tag, "flag_we", {31'b0, flag_we}, {31'b0, is_sc});
    if (is_sc) chk(tag, "flag_val", {31'b0, flag_val}, {31'b0, pass});
    chk(tag, "mem_we", {31'b0, mem_we}, {31'b0, (pass || is_st)});
    if (pass || is_st) begin
      chk(tag, "mem_be", {28'b0, mem_be}, {28'b0, be});
      chk(tag, "mem_addr", mem_addr, a);
      chk(tag, "mem_wdata", mem_wdata, d);
    end
    if (is_ll) begin m_arm = 1'b1; m_adr = a; end
    else if (is_sc) m_arm = 1'b0;
    else if (is_st && (a - (a % 4)) == m_adr) m_arm = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: no reservation after reset, even at address 0
    step(1, 6'h33, 32'h0, 32'hDEAD0001, "R1");
    // R3 / R4: arm then succeed
    step(1, 6'h1B, 32'h0000_1000, 32'h0, "R3");
    step(1, 6'h33, 32'h0000_1000, 32'hCAFE0001, "R4");
    // R6: back-to-back conditional fails
    step(1, 6'h33, 32'h0000_1000, 32'hCAFE0002, "R6");
    // R5: low address bits differ
    step(1, 6'h1B, 32'h0000_2000, 32'h0, "R3");
    step(1, 6'h33, 32'h0000_2002, 32'h11111111, "R5");
    step(1, 6'h33, 32'h0000_2000, 32'h22222222, "R6");
    // R3: replacement by later load-linked
    step(1, 6'h1B, 32'h0000_3000, 32'h0, "R3");
    step(1, 6'h1B, 32'h0000_4000, 32'h0, "R3");
    step(1, 6'h33, 32'h0000_3000, 32'h3, "R5");
    // R7: byte store into reserved word cancels, store proceeds
    step(1, 6'h1B, 32'h0000_5000, 32'h0, "R3");
    step(1, 6'h36, 32'h0000_5003, 32'h000000AB, "R7");
    step(1, 6'h33, 32'h0000_5000, 32'h5, "R7");
    // R8: stores elsewhere keep the reservation
    step(1, 6'h1B, 32'h0000_6000, 32'h0, "R3");
    step(1, 6'h37, 32'h0000_6006, 32'h0000BEEF, "R8");
    step(1, 6'h35, 32'h0000_5FFC, 32'h12345678, "R8");
    step(1, 6'h33, 32'h0000_6000, 32'h6, "R8");
    // R9: lane patterns
    for (int k = 0; k < 4; k++) step(1, 6'h36, 32'h100 + k, 32'hFF, "R9");
    step(1, 6'h37, 32'h200, 32'h1, "R9");
    step(1, 6'h37, 32'h202, 32'h2, "R9");
    step(1, 6'h35, 32'h300, 32'h3, "R9");
    // R2 / R10: invalid or unknown opcodes do nothing
    step(1, 6'h1B, 32'h0000_7000, 32'h0, "R3");
    step(0, 6'h33, 32'h0000_7000, 32'h7, "R2");
    step(0, 6'h35, 32'h0000_7000, 32'h7, "R2");
    step(1, 6'h34, 32'h0000_7000, 32'h7, "R2");
    step(1, 6'h21, 32'h0000_7000, 32'h7, "R10");
    step(1, 6'h33, 32'h0000_7000, 32'h7, "R2");
    // random collisions within a small address pool
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] pick;
      logic [5:0] opc;
      pick = 6'($urandom_range(0, 7));
      case (pick)
        0, 1: opc = 6'h1B;
        2, 3: opc = 6'h33;
        4: opc = 6'h35;
        5: opc = 6'h36;
        6: opc = 6'h37;
        default: opc = 6'h3F;
      endcase
      step($urandom_range(0, 9) != 0, opc, 32'h8000 + $urandom_range(0, 11),
           $urandom, "R4");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule